// File: doc/BRIEF.md
# Interrupt Mode Dispatch Controller

This block takes interrupt requests from user logic and turns each one into an outbound message for a PCIe-style endpoint. The host controls three bits: MSI enable, MSI-X enable, and the INTx disable bit of the command register. The block reads them as inputs and cannot change them. It uses them to pick the mode for each request. In legacy mode a request becomes an INTx assert or deassert message. In MSI mode it becomes a memory-write request that carries a configured 64-bit address and 16-bit data value.

When only MSI-X is enabled, the block sends nothing, because user logic builds those writes itself. When MSI and MSI-X are both enabled, the state is undefined: the block raises an error flag and sends nothing. In both of these cases, and whenever INTx is disabled in legacy mode, the request is answered with a blocked pulse instead of a done pulse. A status output shows whether INTx is currently allowed, and a second output shows whether the block has asserted INTx.

Top module: `irq_mode_dispatch`

## Requirements
- R1: With both enables at 0 and command bit 10 clear, an accepted request sends one message. Its out_kind is 1 (INTx assert) when req_deassert is 0, and 2 (INTx deassert) when req_deassert is 1.
- R2: With msi_en=1 and msix_en=0, an accepted request sends one message with out_kind 3 (MSI write). Its out_addr and out_data equal msi_addr and msi_data as sampled in the accept cycle.
- R3: With msix_en=1 and msi_en=0, an accepted request sends no message and is answered with a one-cycle req_blocked pulse.
- R4: While msi_en and msix_en are both 1, mode_err is 1. An accepted request in that state sends no message and is answered with req_blocked.
- R5: In legacy mode with host_cmd bit 10 set, an accepted request sends no message, gets req_blocked, and leaves intx_asserted unchanged. Other command bits do not gate INTx.
- R6: intx_enabled equals the inverse of host_cmd bit 10 in the same cycle.
- R7: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 1 only when no message is pending. The message (out_valid) or the req_blocked pulse appears in the cycle after the accept.
- R8: req_done pulses for exactly the one cycle after out_valid and out_ready are both 1. req_done and req_blocked are never 1 together.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_kind, out_addr and out_data hold steady, even if the mode or the configuration inputs change. The new mode applies from the next accepted request.
- R10: intx_asserted becomes 1 after an INTx assert message is taken and becomes 0 after an INTx deassert message is taken.
- R11: After reset, out_valid, req_done, req_blocked and intx_asserted are 0, and req_ready returns to 1 once the internal reset release has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msi_en | input | 1 | Host MSI enable |
| msix_en | input | 1 | Host MSI-X enable |
| host_cmd | input | 16 | Host command register; bit 10 disables INTx |
| msi_addr | input | 64 | MSI write address |
| msi_data | input | 16 | MSI write data |
| req_valid | input | 1 | User interrupt request |
| req_deassert | input | 1 | Request is an INTx deassert |
| req_ready | output | 1 | Block can accept a request |
| req_done | output | 1 | Message for the last request was issued |
| req_blocked | output | 1 | Last request was gated off |
| out_valid | output | 1 | Outbound message valid |
| out_ready | input | 1 | Outbound port accepts the message |
| out_kind | output | 2 | 1 INTx assert, 2 INTx deassert, 3 MSI write |
| out_addr | output | 64 | MSI write address |
| out_data | output | 16 | MSI write data |
| mode_err | output | 1 | Both enables set (undefined mode) |
| intx_enabled | output | 1 | INTx allowed by host |
| intx_asserted | output | 1 | INTx currently asserted |

## Verification
The assertions check these rules on every cycle:
- the choice of message kind, or of rejection, from the three control bits at the accept edge;
- the error flag;
- the INTx status output;
- the exclusion between done and blocked;
- holding of a stalled message;
- tracking of the INTx asserted state.

Some behaviour shows up only in the bench scenarios: the address and data values a message carries, a mode change while the outbound port stalls, the exact cycle of the done pulse, and the order in which messages come out. A scoreboard compares each of these against what the requests predicted.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_MSI    = 2'd1,
    MODE_MSIX   = 2'd2,
    MODE_UNDEF  = 2'd3
  } irq_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } disp_state_e;

  localparam logic [1:0] KIND_NONE     = 2'd0;
  localparam logic [1:0] KIND_INTX_ON  = 2'd1;
  localparam logic [1:0] KIND_INTX_OFF = 2'd2;
  localparam logic [1:0] KIND_MSI_WR   = 2'd3;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/irq_mode_decode.sv
module irq_mode_decode
  import irq_dispatch_pkg::*;
#(
  parameter int CMD_W        = 16,
  parameter int INTX_DIS_BIT = 10
) (
  input  logic             msi_en,
  input  logic             msix_en,
  input  logic [CMD_W-1:0] host_cmd,
  input  logic             deassert,
  output irq_mode_e        mode,
  output logic             intx_ok,
  output logic             emit,
  output logic [1:0]       kind
);
  always_comb begin
    intx_ok = ~host_cmd[INTX_DIS_BIT];
    unique case ({msix_en, msi_en})
      2'b00:   mode = MODE_LEGACY;
      2'b01:   mode = MODE_MSI;
      2'b10:   mode = MODE_MSIX;
      default: mode = MODE_UNDEF;
    endcase
    emit = 1'b0;
    kind = KIND_NONE;
    case (mode)
      MODE_LEGACY: begin
        emit = intx_ok;
        kind = deassert ? KIND_INTX_OFF : KIND_INTX_ON;
      end
      MODE_MSI: begin
        emit = 1'b1;
        kind = KIND_MSI_WR;
      end
      default: begin
        emit = 1'b0;
        kind = KIND_NONE;
      end
    endcase
  end
endmodule

// File: rtl/irq_dispatch_fsm.sv
module irq_dispatch_fsm
  import irq_dispatch_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              emit,
  input  logic [1:0]        kind_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              out_ready,
  output logic              req_ready,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_fire,
  output logic              req_done,
  output logic              req_blocked
);
  disp_state_e       state_q, state_d;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q, done_d;
  logic              blk_q, blk_d;
  logic              accept, load_en;

  always_comb begin
    accept   = req_valid & (state_q == ST_IDLE);
    out_fire = (state_q == ST_SEND) & out_ready;
    load_en  = accept & emit;
    done_d   = out_fire;
    blk_d    = accept & ~emit;
    state_d  = state_q;
    case (state_q)
      ST_IDLE: if (load_en)  state_d = ST_SEND;
      ST_SEND: if (out_fire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      blk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      blk_q   <= blk_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      kind_q <= kind_in;
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  assign req_ready   = rst_n & (state_q == ST_IDLE);
  assign out_valid   = (state_q == ST_SEND);
  assign out_kind    = kind_q;
  assign out_addr    = addr_q;
  assign out_data    = data_q;
  assign req_done    = done_q;
  assign req_blocked = blk_q;
endmodule

// File: rtl/irq_intx_track.sv
module irq_intx_track
  import irq_dispatch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [1:0] kind,
  output logic       asserted
);
  logic q, d, en;

  always_comb begin
    en = fire & ((kind == KIND_INTX_ON) | (kind == KIND_INTX_OFF));
    d  = (kind == KIND_INTX_ON);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d;
  end

  assign asserted = q;
endmodule

// File: rtl/irq_mode_dispatch.sv
module irq_mode_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter int DATA_W       = 16,
  parameter int CMD_W        = 16,
  parameter int INTX_DIS_BIT = 10,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_en,
  input  logic              msix_en,
  input  logic [CMD_W-1:0]  host_cmd,
  input  logic [ADDR_W-1:0] msi_addr,
  input  logic [DATA_W-1:0] msi_data,
  input  logic              req_valid,
  input  logic              req_deassert,
  output logic              req_ready,
  output logic              req_done,
  output logic              req_blocked,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              mode_err,
  output logic              intx_enabled,
  output logic              intx_asserted
);
  logic       rst_n_int;
  irq_mode_e  mode;
  logic       emit;
  logic [1:0] kind;
  logic       fire;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_int)
  );

  irq_mode_decode #(.CMD_W(CMD_W), .INTX_DIS_BIT(INTX_DIS_BIT)) u_dec (
    .msi_en(msi_en), .msix_en(msix_en), .host_cmd(host_cmd),
    .deassert(req_deassert), .mode(mode), .intx_ok(intx_enabled),
    .emit(emit), .kind(kind)
  );

  irq_dispatch_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_int), .req_valid(req_valid), .emit(emit),
    .kind_in(kind), .addr_in(msi_addr), .data_in(msi_data),
    .out_ready(out_ready), .req_ready(req_ready), .out_valid(out_valid),
    .out_kind(out_kind), .out_addr(out_addr), .out_data(out_data),
    .out_fire(fire), .req_done(req_done), .req_blocked(req_blocked)
  );

  irq_intx_track u_trk (
    .clk(clk), .rst_n(rst_n_int), .fire(fire), .kind(out_kind),
    .asserted(intx_asserted)
  );

  assign mode_err = (mode == MODE_UNDEF);
endmodule

// File: rtl/irq_mode_dispatch_chk.sv
module irq_mode_dispatch_chk #(
  parameter int ADDR_W       = 64,
  parameter int DATA_W       = 16,
  parameter int CMD_W        = 16,
  parameter int INTX_DIS_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msi_en,
  input logic              msix_en,
  input logic [CMD_W-1:0]  host_cmd,
  input logic              req_valid,
  input logic              req_deassert,
  input logic              req_ready,
  input logic              req_done,
  input logic              req_blocked,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_kind,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data,
  input logic              mode_err,
  input logic              intx_enabled,
  input logic              intx_asserted
);
  logic acc;
  assign acc = req_valid & req_ready;

  p_legacy_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !msi_en && !msix_en && !host_cmd[INTX_DIS_BIT])
      |=> (out_valid && out_kind == {$past(req_deassert), !$past(req_deassert)}));

  p_msi_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && msi_en && !msix_en) |=> (out_valid && out_kind == 2'd3));

  p_msix_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && msix_en && !msi_en) |=> (req_blocked && !out_valid));

  p_undef_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && msi_en && msix_en) |=> (req_blocked && !out_valid));

  p_undef_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (msi_en && msix_en));

  p_intx_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !msi_en && !msix_en && host_cmd[INTX_DIS_BIT])
      |=> (req_blocked && !out_valid && $stable(intx_asserted)));

  p_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    intx_enabled != host_cmd[INTX_DIS_BIT]);

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (req_done && !out_valid));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_done && req_blocked));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind)
      && $stable(out_addr) && $stable(out_data)));

  p_track_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_kind == 2'd1) |=> intx_asserted);

  p_track_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_kind == 2'd2) |=> !intx_asserted);
endmodule

bind irq_mode_dispatch irq_mode_dispatch_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W), .INTX_DIS_BIT(INTX_DIS_BIT)
) u_chk (.*);

// File: tb/irq_mode_dispatch_tb_top.sv
`timescale 1ns/1ps
module irq_mode_dispatch_tb_top;
  typedef struct packed {
    logic [1:0]  kind;
    logic [63:0] addr;
    logic [15:0] data;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_en = 1'b0, msix_en = 1'b0;
  logic [15:0] host_cmd = '0;
  logic [63:0] msi_addr = '0;
  logic [15:0] msi_data = '0;
  logic        req_valid = 1'b0, req_deassert = 1'b0;
  logic        out_ready = 1'b1;
  logic        req_ready, req_done, req_blocked, out_valid;
  logic [1:0]  out_kind;
  logic [63:0] out_addr;
  logic [15:0] out_data;
  logic        mode_err, intx_enabled, intx_asserted;

  int   n_cmp = 0, n_bad = 0;
  bit   ended = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  irq_mode_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .msix_en(msix_en),
    .host_cmd(host_cmd), .msi_addr(msi_addr), .msi_data(msi_data),
    .req_valid(req_valid), .req_deassert(req_deassert), .req_ready(req_ready),
    .req_done(req_done), .req_blocked(req_blocked), .out_valid(out_valid),
    .out_ready(out_ready), .out_kind(out_kind), .out_addr(out_addr),
    .out_data(out_data), .mode_err(mode_err), .intx_enabled(intx_enabled),
    .intx_asserted(intx_asserted)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: pops an expected item on every outbound handshake
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R7 unexpected message", {62'd0, out_kind}, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(out_kind == e.kind, (e.kind == 2'd3) ? "R2 kind" : "R1 kind",
              {62'd0, out_kind}, {62'd0, e.kind});
          if (e.kind == 2'd3) begin
            chk(out_addr == e.addr, "R2 R9 addr", out_addr, e.addr);
            chk(out_data == e.data, "R2 R9 data", {48'd0, out_data}, {48'd0, e.data});
          end
        end
      end
    end
  end

  // driver: issues a request with out_ready high and checks handshake timing
  task automatic do_req(input logic d, input logic [1:0] exp_kind, input string rq);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_deassert = d;
    if (exp_kind != 2'd0) begin
      exp_t e;
      e.kind = exp_kind;
      e.addr = msi_addr;
      e.data = msi_data;
      q.push_back(e);
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_kind != 2'd0) begin
      chk(out_valid && !req_blocked, {rq, " R7 message follows accept"}, {63'd0, out_valid}, 64'd1);
      @(negedge clk);
      chk(req_done && !req_blocked, "R8 done pulse", {63'd0, req_done}, 64'd1);
      @(negedge clk);
      chk(!req_done, "R8 done one cycle", {63'd0, req_done}, 64'd0);
    end else begin
      chk(req_blocked && !out_valid, {rq, " blocked"}, {63'd0, req_blocked}, 64'd1);
      @(negedge clk);
      chk(!req_blocked && !out_valid, {rq, " no message"}, {63'd0, out_valid}, 64'd0);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !req_done && !req_blocked && !intx_asserted && !req_ready,
        "R11 in reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !out_valid && !intx_asserted, "R11 after release", {63'd0, req_ready}, 64'd1);

    // INTx status
    chk(intx_enabled == 1'b1, "R6 enabled", {63'd0, intx_enabled}, 64'd1);
    host_cmd = 16'h0400;
    #1;
    chk(intx_enabled == 1'b0, "R6 disabled", {63'd0, intx_enabled}, 64'd0);
    host_cmd = 16'h0000;

    // legacy assert / deassert
    do_req(1'b0, 2'd1, "R1 assert");
    chk(intx_asserted, "R10 set", {63'd0, intx_asserted}, 64'd1);
    do_req(1'b1, 2'd2, "R1 deassert");
    chk(!intx_asserted, "R10 clear", {63'd0, intx_asserted}, 64'd0);

    // INTx gating by bit 10 only
    do_req(1'b0, 2'd1, "R1 assert again");
    host_cmd = 16'h0400;
    do_req(1'b1, 2'd0, "R5 gated");
    chk(intx_asserted, "R5 state kept", {63'd0, intx_asserted}, 64'd1);
    host_cmd = 16'hFBFF;
    do_req(1'b1, 2'd2, "R5 other bits no gate");
    chk(!intx_asserted, "R10 clear after gate", {63'd0, intx_asserted}, 64'd0);
    host_cmd = 16'h0000;

    // MSI mode
    msi_en = 1'b1;
    msi_addr = 64'hFEE0_1234_0000_0040;
    msi_data = 16'hA5C3;
    do_req(1'b0, 2'd3, "R2 first");
    msi_addr = 64'h0000_0001_8000_0010;
    msi_data = 16'h0007;
    host_cmd = 16'h0400;
    do_req(1'b1, 2'd3, "R2 ignores INTx bits");
    host_cmd = 16'h0000;

    // MSI-X only
    msi_en = 1'b0;
    msix_en = 1'b1;
    #1;
    chk(!mode_err, "R3 no error flag", {63'd0, mode_err}, 64'd0);
    do_req(1'b0, 2'd0, "R3 msix");

    // both enables
    msi_en = 1'b1;
    #1;
    chk(mode_err, "R4 error flag", {63'd0, mode_err}, 64'd1);
    do_req(1'b0, 2'd0, "R4 undefined");
    msix_en = 1'b0;
    #1;
    chk(!mode_err, "R4 flag clears", {63'd0, mode_err}, 64'd0);

    // stall with mode change
    out_ready = 1'b0;
    msi_addr = 64'hDEAD_BEEF_CAFE_0008;
    msi_data = 16'h1234;
    @(negedge clk);
    req_valid = 1'b1;
    begin
      exp_t e;
      e.kind = 2'd3; e.addr = msi_addr; e.data = msi_data;
      q.push_back(e);
    end
    @(negedge clk);
    req_valid = 1'b0;
    msi_en = 1'b0;
    msix_en = 1'b1;
    msi_addr = 64'h1;
    msi_data = 16'h1;
    for (int i = 0; i < 4; i++) begin
      chk(out_valid && !req_ready && out_kind == 2'd3, "R9 R7 held while stalled",
          {62'd0, out_kind}, 64'd3);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(req_done && !out_valid, "R8 done after stall", {63'd0, req_done}, 64'd1);
    msix_en = 1'b0;
    do_req(1'b0, 2'd1, "R9 new mode applies");
    do_req(1'b1, 2'd2, "R1 final deassert");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R9 all messages drained", q.size(), 64'd0);
    finish_run();
  end
endmodule